// File: doc/BRIEF.md
# Control-Page Write Gate

This block sits between a serial-bus slave front end and a 272-byte register and table array. For each write transaction it decides whether the bytes may be committed. The decision depends on a volatile write-enable bit, the region being targeted and the shape of the transaction. The front end reports three things: the start of a write transaction together with its address byte, each data byte it has acknowledged, and the STOP condition. The gate answers with array write strobes, a one-cycle rejection flag, and a one-cycle request to start the nonvolatile programming cycle.

**Addressing.** The array is organised as 17 pages of 16 bytes. An address byte of FFh selects location 100h. In the general region and the two tables, bytes are forwarded as they arrive, and the in-page offset wraps inside the 16-byte page.

**Control page (80h–8Fh).** This page has its own rules:
- Some bytes accept only single-byte writes.
- One four-byte group accepts only an exact, atomic four-byte write.
- The top half of the page is reserved.

Control-page bytes are held until STOP. If the transaction is legal, they are then replayed to the array on consecutive cycles, with the reserved bits cleared.

The front end must not begin a new transaction until a replay (at most four cycles after STOP) has finished. Transactions that carry only an address byte, such as those that set up a read, pass through untouched.

Top module: `cwg_top`

## Requirements
- R1: While the write-enable bit is 0, a transaction that carries data to any location other than 86h produces no `wrEn`, one `wrErr` pulse after STOP, and no `nvBusyStart`.
- R2: The write-enable bit (`welOut`) is 0 after reset. A single-byte write to 86h always commits, whatever the current value of the bit. The bit then takes bit 1 of the masked byte, in the same cycle that the write appears on `wrEn`.
- R3: With the write-enable bit at 1, each data byte to 00h–7Fh or 90h–10Fh appears on `wrEn` in arrival order. The low 4 address bits start at the addressed offset and wrap from F to 0 while the upper bits stay fixed. One `nvBusyStart` pulse follows STOP.
- R4: An address byte of FFh selects location 100h as the first target.
- R5: With the write-enable bit at 1, address 81h followed by exactly four data bytes and STOP commits the bytes to 81h, 82h, 83h and 84h, in that order, on consecutive cycles. `nvBusyStart` pulses together with the 84h write.
- R6: A transaction to 81h carrying other than four data bytes, or any data-carrying transaction to 82h–84h, writes nothing and pulses `wrErr`.
- R7: Locations 80h, 85h, 86h and 87h accept exactly one data byte. A longer transaction writes nothing and pulses `wrErr`.
- R8: Any data-carrying transaction to 88h–8Fh writes nothing and pulses `wrErr`.
- R9: Committed control bytes are ANDed with a keep mask: 7Fh at 80h, FFh at 81h–84h, 3Fh at 85h, 86h at 86h, and FFh at 87h.
- R10: Commits to the volatile locations 86h and 87h do not pulse `nvBusyStart`. Every other accepted commit pulses it exactly once.
- R11: A transaction with no data bytes produces no write, no error and no busy pulse.
- R12: After reset, `wrEn`, `wrErr`, `nvBusyStart` and `welOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txnStart | input | 1 | One-cycle pulse: a write transaction begins; `addrByte` is valid |
| addrByte | input | 8 | Address byte received after the slave address |
| dataValid | input | 1 | One-cycle pulse per acknowledged data byte |
| dataByte | input | 8 | Data byte, valid with `dataValid` |
| txnStop | input | 1 | One-cycle pulse: STOP ended the transaction |
| wrEn | output | 1 | Array write strobe |
| wrAddr | output | 9 | Array location being written |
| wrData | output | 8 | Byte being written |
| wrErr | output | 1 | One-cycle pulse: the transaction was rejected |
| nvBusyStart | output | 1 | One-cycle pulse: start the nonvolatile programming cycle |
| welOut | output | 1 | Current write-enable bit |

## Verification
Two updates can land in the same cycle. When 86h is committed, the array write and the change of the write-enable bit appear together. The last write of a four-byte group coincides with the busy pulse. The bench clears the enable bit through 86h and then tries a group write at once: it expects the rejection flag and no write, which shows that the new bit value was in effect at the decision. For each accepted group it counts the busy pulses within the replay window, and a checker ties any rise of `welOut` to a simultaneous 86h write.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
  localparam int ADDR_W    = 9;
  localparam int DATA_W    = 8;
  localparam int PAGE_BITS = 4;
  localparam int GROUP_LEN = 4;
  localparam int GIDX_W    = $clog2(GROUP_LEN);
  localparam int CNT_W     = $clog2(GROUP_LEN + 2);
  localparam int WEL_BIT   = 1;

  localparam logic [ADDR_W-PAGE_BITS-1:0] CTRL_PAGE = 'h08;
  localparam logic [ADDR_W-1:0]           HIGH_LOC  = 'h100;
  localparam logic [PAGE_BITS-1:0] OFF_GROUP  = 4'h1;
  localparam logic [PAGE_BITS-1:0] OFF_ENABLE = 4'h6;
  localparam logic [PAGE_BITS-1:0] OFF_STATUS = 4'h7;

  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_DRAIN} seqState_t;

  typedef struct packed {
    logic              loadBase;
    logic              stream;
    logic              capture;
    logic [GIDX_W-1:0] capIdx;
    logic              drain;
    logic [GIDX_W-1:0] drainIdx;
  } dpStrobe_t;

  function automatic logic [DATA_W-1:0] keepMask(input logic [PAGE_BITS-1:0] off);
    case (off)
      4'h0:    keepMask = 8'h7F;
      4'h5:    keepMask = 8'h3F;
      4'h6:    keepMask = 8'h86;
      default: keepMask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/cwg_ctrl.sv
module cwg_ctrl
  import cwg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnStart,
  input  logic              dataValid,
  input  logic              txnStop,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              wel,
  output dpStrobe_t         strb,
  output logic              errPulse,
  output logic              busyPulse
);
  seqState_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [GIDX_W-1:0] dIdx, dLast;

  logic                 inCtrl, isGroup, isSingle, isVol, ctrlOk;
  logic [PAGE_BITS-1:0] off;

  always_comb begin
    inCtrl   = baseAddr[ADDR_W-1:PAGE_BITS] == CTRL_PAGE;
    off      = baseAddr[PAGE_BITS-1:0];
    isGroup  = off == OFF_GROUP;
    isSingle = (off == 4'h0) || ((off >= 4'h5) && (off <= OFF_STATUS));
    isVol    = (off == OFF_ENABLE) || (off == OFF_STATUS);
    ctrlOk   = inCtrl &&
               ((isSingle && cnt == CNT_W'(1) && (wel || off == OFF_ENABLE)) ||
                (isGroup && cnt == CNT_W'(GROUP_LEN) && wel));
  end

  always_comb begin
    strb          = '0;
    strb.loadBase = (state == ST_IDLE) && txnStart;
    strb.stream   = (state == ST_RECV) && dataValid && !inCtrl && wel;
    strb.capture  = (state == ST_RECV) && dataValid && inCtrl && (cnt < CNT_W'(GROUP_LEN));
    strb.capIdx   = cnt[GIDX_W-1:0];
    strb.drain    = (state == ST_DRAIN);
    strb.drainIdx = dIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      dIdx      <= '0;
      dLast     <= '0;
      errPulse  <= 1'b0;
      busyPulse <= 1'b0;
    end else begin
      errPulse  <= 1'b0;
      busyPulse <= 1'b0;
      case (state)
        ST_IDLE: if (txnStart) begin
          state <= ST_RECV;
          cnt   <= '0;
        end
        ST_RECV: begin
          if (dataValid && cnt != '1) cnt <= cnt + CNT_W'(1);
          if (txnStop) begin
            state <= ST_IDLE;
            if (cnt != '0) begin
              if (!inCtrl) begin
                busyPulse <= wel;
                errPulse  <= !wel;
              end else if (ctrlOk) begin
                state <= ST_DRAIN;
                dIdx  <= '0;
                dLast <= GIDX_W'(cnt - CNT_W'(1));
              end else begin
                errPulse <= 1'b1;
              end
            end
          end
        end
        ST_DRAIN: begin
          if (dIdx == dLast) begin
            state     <= ST_IDLE;
            busyPulse <= !isVol;
          end else begin
            dIdx <= dIdx + GIDX_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cwg_datapath.sv
module cwg_datapath
  import cwg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [7:0]        addrByte,
  input  logic [DATA_W-1:0] dataByte,
  output logic [ADDR_W-1:0] baseAddr,
  output logic              wel,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);
  logic [PAGE_BITS-1:0] ptrLo;
  logic [DATA_W-1:0]    grpBuf [GROUP_LEN];
  logic [ADDR_W-1:0]    mapped, drainAddr;
  logic [DATA_W-1:0]    drainData;

  always_comb begin
    mapped    = (addrByte == 8'hFF) ? HIGH_LOC : ADDR_W'(addrByte);
    drainAddr = baseAddr + ADDR_W'(strb.drainIdx);
    drainData = grpBuf[strb.drainIdx] & keepMask(drainAddr[PAGE_BITS-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      ptrLo    <= '0;
      wel      <= 1'b0;
      wrEn     <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrEn <= 1'b0;
      if (strb.loadBase) begin
        baseAddr <= mapped;
        ptrLo    <= mapped[PAGE_BITS-1:0];
      end
      if (strb.stream) begin
        wrEn   <= 1'b1;
        wrAddr <= {baseAddr[ADDR_W-1:PAGE_BITS], ptrLo};
        wrData <= dataByte;
        ptrLo  <= ptrLo + PAGE_BITS'(1);
      end
      if (strb.drain) begin
        wrEn   <= 1'b1;
        wrAddr <= drainAddr;
        wrData <= drainData;
        if (drainAddr[PAGE_BITS-1:0] == OFF_ENABLE) wel <= drainData[WEL_BIT];
      end
    end
  end

  for (genvar g = 0; g < GROUP_LEN; g++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rstN) grpBuf[g] <= '0;
      else if (strb.capture && strb.capIdx == GIDX_W'(g)) grpBuf[g] <= dataByte;
    end
  end
endmodule

// File: rtl/cwg_top.sv
module cwg_top
  import cwg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnStart,
  input  logic [7:0]        addrByte,
  input  logic              dataValid,
  input  logic [DATA_W-1:0] dataByte,
  input  logic              txnStop,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrErr,
  output logic              nvBusyStart,
  output logic              welOut
);
  dpStrobe_t         strb;
  logic [ADDR_W-1:0] baseAddr;

  cwg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txnStart(txnStart), .dataValid(dataValid),
    .txnStop(txnStop), .baseAddr(baseAddr), .wel(welOut), .strb(strb),
    .errPulse(wrErr), .busyPulse(nvBusyStart)
  );

  cwg_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addrByte(addrByte),
    .dataByte(dataByte), .baseAddr(baseAddr), .wel(welOut),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );
endmodule

// File: rtl/cwg_chk.sv
module cwg_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [8:0] wrAddr,
  input logic [7:0] wrData,
  input logic       wrErr,
  input logic       nvBusyStart,
  input logic       welOut
);
  // R1
  err_busy_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrErr && nvBusyStart));
  // R1
  general_needs_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr[8:4] != 5'h08) |-> welOut);
  // R8
  reserved_untouched_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !(wrAddr[8:4] == 5'h08 && wrAddr[3]));
  // R9
  mask_80_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 9'h080) |-> !wrData[7]);
  // R2
  wel_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(welOut) |-> (wrEn && wrAddr == 9'h086));
  // R10
  volatile_no_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    nvBusyStart |-> !(wrEn && (wrAddr == 9'h086 || wrAddr == 9'h087)));
  // R5
  group_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 9'h082) |-> $past(wrEn && wrAddr == 9'h081));
endmodule

bind cwg_top cwg_chk u_chk (.*);

// File: tb/cwg_top_tb.sv
`timescale 1ns/1ps
module cwg_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txnStart = 1'b0, dataValid = 1'b0, txnStop = 1'b0;
  logic [7:0] addrByte = '0, dataByte = '0;
  logic       wrEn, wrErr, nvBusyStart, welOut;
  logic [8:0] wrAddr;
  logic [7:0] wrData;

  always #2 clk = ~clk;

  cwg_top u_dut (.*);

  typedef struct packed {
    logic [7:0] addr;
    logic [4:0] n;
    logic [7:0] seed;
    logic [4:0] expWr;
    logic       expErr;
    logic       expBusy;
    logic       expWel;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{8'h10, 5'd1,  8'h11, 5'd0,  1'b1, 1'b0, 1'b0, 4'd1},
    '{8'h86, 5'd1,  8'h02, 5'd1,  1'b0, 1'b0, 1'b1, 4'd2},
    '{8'h10, 5'd3,  8'h20, 5'd3,  1'b0, 1'b1, 1'b1, 4'd3},
    '{8'h0B, 5'd12, 8'h30, 5'd12, 1'b0, 1'b1, 1'b1, 4'd3},
    '{8'hFF, 5'd2,  8'h60, 5'd2,  1'b0, 1'b1, 1'b1, 4'd4},
    '{8'h81, 5'd4,  8'h40, 5'd4,  1'b0, 1'b1, 1'b1, 4'd5},
    '{8'h81, 5'd3,  8'h44, 5'd0,  1'b1, 1'b0, 1'b1, 4'd6},
    '{8'h81, 5'd5,  8'h48, 5'd0,  1'b1, 1'b0, 1'b1, 4'd6},
    '{8'h82, 5'd4,  8'h4C, 5'd0,  1'b1, 1'b0, 1'b1, 4'd6},
    '{8'h80, 5'd2,  8'h70, 5'd0,  1'b1, 1'b0, 1'b1, 4'd7},
    '{8'h80, 5'd1,  8'hFF, 5'd1,  1'b0, 1'b1, 1'b1, 4'd9},
    '{8'h88, 5'd1,  8'h12, 5'd0,  1'b1, 1'b0, 1'b1, 4'd8},
    '{8'h85, 5'd1,  8'hFF, 5'd1,  1'b0, 1'b1, 1'b1, 4'd9},
    '{8'h87, 5'd1,  8'h55, 5'd1,  1'b0, 1'b0, 1'b1, 4'd10},
    '{8'h50, 5'd0,  8'h00, 5'd0,  1'b0, 1'b0, 1'b1, 4'd11},
    '{8'h86, 5'd1,  8'hFD, 5'd1,  1'b0, 1'b0, 1'b0, 4'd2},
    '{8'h81, 5'd4,  8'h90, 5'd0,  1'b1, 1'b0, 1'b0, 4'd1},
    '{8'hC0, 5'd1,  8'h33, 5'd0,  1'b1, 1'b0, 1'b0, 4'd1}
  };

  int checks = 0, fails = 0;
  int wrCount = 0, errCount = 0, busyCount = 0;
  logic [8:0] logA [256];
  logic [7:0] logD [256];
  bit finished = 1'b0;

  function automatic string reqName(input int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11"; default: return "R12";
    endcase
  endfunction

  // keep masks as listed in R9
  function automatic logic [7:0] maskOf(input logic [3:0] off);
    case (off)
      4'h0: return 8'h7F;
      4'h5: return 8'h3F;
      4'h6: return 8'h86;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN) begin
    if (wrEn) begin
      logA[wrCount % 256] <= wrAddr;
      logD[wrCount % 256] <= wrData;
      wrCount <= wrCount + 1;
    end
    if (wrErr) errCount <= errCount + 1;
    if (nvBusyStart) busyCount <= busyCount + 1;
  end

  task automatic runTxn(input logic [7:0] a, input int n, input logic [7:0] seed);
    @(negedge clk); txnStart = 1'b1; addrByte = a;
    @(negedge clk); txnStart = 1'b0;
    for (int i = 0; i < n; i++) begin
      dataValid = 1'b1; dataByte = seed + 8'(i);
      @(negedge clk);
    end
    dataValid = 1'b0; txnStop = 1'b1;
    @(negedge clk); txnStop = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12", "wrEn", wrEn, 0);
    check("R12", "wrErr", wrErr, 0);
    check("R12", "nvBusyStart", nvBusyStart, 0);
    check("R12", "welOut", welOut, 0);

    for (int v = 0; v < NV; v++) begin
      int w0, e0, b0;
      logic [8:0] base, ea;
      logic [7:0] ed;
      string rq;
      rq = reqName(int'(VECS[v].req));
      w0 = wrCount; e0 = errCount; b0 = busyCount;
      runTxn(VECS[v].addr, int'(VECS[v].n), VECS[v].seed);
      check(rq, $sformatf("v%0d write count", v), wrCount - w0, int'(VECS[v].expWr));
      check(rq, $sformatf("v%0d error pulses", v), errCount - e0, int'(VECS[v].expErr));
      check(rq, $sformatf("v%0d busy pulses", v), busyCount - b0, int'(VECS[v].expBusy));
      check(rq, $sformatf("v%0d welOut", v), welOut, int'(VECS[v].expWel));
      base = (VECS[v].addr == 8'hFF) ? 9'h100 : {1'b0, VECS[v].addr};
      for (int i = 0; i < int'(VECS[v].expWr) && (wrCount - w0) == int'(VECS[v].expWr); i++) begin
        if (base[8:4] == 5'h08) begin
          ea = base + 9'(i);
          ed = (VECS[v].seed + 8'(i)) & maskOf(ea[3:0]);
        end else begin
          ea = {base[8:4], base[3:0] + 4'(i)};
          ed = VECS[v].seed + 8'(i);
        end
        check(rq, $sformatf("v%0d addr %0d", v, i), logA[(w0 + i) % 256], ea);
        check(rq, $sformatf("v%0d data %0d", v, i), logD[(w0 + i) % 256], ed);
      end
    end

    // R2: WEL set, then reset clears it
    runTxn(8'h86, 1, 8'h02);
    check("R2", "welOut set again", welOut, 1);
    rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2", "welOut after reset", welOut, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule